// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small accumulator-based processor core. Each evaluation takes an operation code, the accumulator value, a second operand (a memory byte or an immediate), and the current carry and half-carry flags. It returns an 8-bit result, the next values of the carry, half-carry, zero and overflow flags, and one write enable per flag. The core writes a flag only when its enable is high.

Subtraction uses the inverted-borrow convention. Carry high means no borrow occurred. Half-carry high means no borrow passed from the upper nibble into the lower nibble. The decimal-adjust operation reads both flags to correct a packed-BCD sum.

Conditional-skip instructions get a separate `skip_o` output. The sequencer uses it to discard the next instruction. The skip forms that increment or decrement also return the modified byte, so it can be written back.

Top module: `alu8_flags`

## Requirements
- R1: `op_i` encodes the operations as follows. 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 DAA, 5 AND, 6 OR, 7 XOR, 8 CPL, 9 RL, 10 RR, 11 RLC, 12 RRC, 13 INC, 14 DEC, 15 SZ, 16 SNZ, 17 SIZ, 18 SDZ. Flag outputs and enables are ordered {C, AC, Z, OV}.
- R2: ADD returns A+B and ADC returns A+B+C. C is the carry out of bit 7 and AC is the carry out of bit 3. All four flag enables are high.
- R3: SUB returns A+~B+1 and SBC returns A+~B+C. C is high when no borrow occurs and AC is high when no nibble borrow occurs. All four flag enables are high.
- R4: For every operation that enables Z, Z is high exactly when the 8-bit result is zero.
- R5: For ADD, ADC, SUB and SBC, OV is the carry into bit 7 XOR the carry out of bit 7.
- R6: DAA adds 0x06 to A when A[3:0] > 9 or AC is set. It adds 0x60 when A > 0x99 or C is set. C becomes high exactly when the 0x60 correction was applied. Only the C enable is high.
- R7: AND, OR and XOR combine A with B. CPL inverts B, INC returns B+1 and DEC returns B-1. Only the Z enable is high for these six operations.
- R8: RL and RR rotate B left or right by one bit, with the end bit wrapping around. No flag enable is high.
- R9: RLC and RRC rotate B through carry. The old C enters the vacated bit and the bit shifted out becomes the new C. Only the C enable is high.
- R10: SZ and SNZ return B and skip when B is zero or non-zero, respectively. SIZ returns B+1 and SDZ returns B-1, and each skips when its result is zero. No flag enable is high for the four skip forms.
- R11: `skip_o` is low for every operation other than SZ, SNZ, SIZ and SDZ.
- R12: Opcodes 19 to 31 return a zero result, no flag enables and no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see R1) |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Memory or immediate operand B |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| result_o | output | 8 | Operation result |
| flags_o | output | 4 | Next flag values {C, AC, Z, OV} |
| flags_we_o | output | 4 | Per-flag write enables {C, AC, Z, OV} |
| skip_o | output | 1 | Skip the next instruction |

## Verification
Every output is purely combinational, so all results are due in the same cycle the inputs are applied, with no register in the path. The bench drives the inputs just after a rising clock edge and samples half a period later. This leaves the inputs settled and keeps sampling away from any edge. Flag values are compared only where the bench expects the matching enable to be high. The enables themselves are always compared.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic [4:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       c_i,
  input  logic       ac_i,
  output logic [7:0] result_o,
  output logic [3:0] flags_o,
  output logic [3:0] flags_we_o,
  output logic       skip_o
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7;
  localparam logic [4:0] OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11;
  localparam logic [4:0] OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15;
  localparam logic [4:0] OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18;

  logic       is_sub, cin, hi_fix, lo_fix;
  logic [7:0] b_eff;
  logic [8:0] sum;
  logic [4:0] lo_sum;
  logic [7:0] low7;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SBC);
  assign b_eff  = is_sub ? ~opnd_i : opnd_i;
  assign cin    = (op_i == OP_SUB) ? 1'b1 : ((op_i == OP_ADC) || (op_i == OP_SBC)) ? c_i : 1'b0;
  assign sum    = {1'b0, acc_i} + {1'b0, b_eff} + {8'd0, cin};
  assign lo_sum = {1'b0, acc_i[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, cin};
  assign low7   = {1'b0, acc_i[6:0]} + {1'b0, b_eff[6:0]} + {7'd0, cin};
  assign lo_fix = (acc_i[3:0] > 4'd9) || ac_i;
  assign hi_fix = (acc_i > 8'h99) || c_i;

  always_comb begin
    logic [7:0] res;
    logic       c_n, skp;
    logic [3:0] we;
    res = 8'h00;
    c_n = 1'b0;
    skp = 1'b0;
    we  = 4'b0000;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res = sum[7:0]; c_n = sum[8]; we = 4'b1111;
      end
      OP_DAA: begin
        res = acc_i + {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
        c_n = hi_fix; we = 4'b1000;
      end
      OP_AND: begin res = acc_i & opnd_i; we = 4'b0010; end
      OP_OR:  begin res = acc_i | opnd_i; we = 4'b0010; end
      OP_XOR: begin res = acc_i ^ opnd_i; we = 4'b0010; end
      OP_CPL: begin res = ~opnd_i;        we = 4'b0010; end
      OP_INC: begin res = opnd_i + 8'd1;  we = 4'b0010; end
      OP_DEC: begin res = opnd_i - 8'd1;  we = 4'b0010; end
      OP_RL:  res = {opnd_i[6:0], opnd_i[7]};
      OP_RR:  res = {opnd_i[0], opnd_i[7:1]};
      OP_RLC: begin res = {opnd_i[6:0], c_i}; c_n = opnd_i[7]; we = 4'b1000; end
      OP_RRC: begin res = {c_i, opnd_i[7:1]}; c_n = opnd_i[0]; we = 4'b1000; end
      OP_SZ:  begin res = opnd_i; skp = (opnd_i == 8'h00); end
      OP_SNZ: begin res = opnd_i; skp = (opnd_i != 8'h00); end
      OP_SIZ: begin res = opnd_i + 8'd1; skp = (res == 8'h00); end
      OP_SDZ: begin res = opnd_i - 8'd1; skp = (res == 8'h00); end
      default: ;
    endcase
    result_o   = res;
    flags_o    = {c_n, lo_sum[4], (res == 8'h00), low7[7] ^ sum[8]};
    flags_we_o = we;
    skip_o     = skp;

    if (!$isunknown({op_i, acc_i, opnd_i, c_i, ac_i})) begin
      if (op_i == OP_ADD)
        AST_ADD_SUM: assert ({flags_o[3], result_o} == 9'(acc_i) + 9'(opnd_i)); // R2
      if (op_i == OP_SUB)
        AST_SUB_NOBORROW: assert (flags_o[3] == (acc_i >= opnd_i)); // R3
      if (flags_we_o[1])
        AST_ZERO_FLAG: assert (flags_o[1] == ($countones(result_o) == 0)); // R4
      if (op_i == OP_ADD)
        AST_OV_SIGN: assert (flags_o[0] == ((acc_i[7] == opnd_i[7]) && (result_o[7] != acc_i[7]))); // R5
      if (op_i == OP_RL || op_i == OP_RR)
        AST_ROT_NOFLAGS: assert (flags_we_o == 4'b0000 && $countones(result_o) == $countones(opnd_i)); // R8
      if (op_i == OP_RLC)
        AST_RLC_CARRY: assert (flags_o[3] == opnd_i[7] && result_o[0] == c_i); // R9
      if (op_i < OP_SZ || op_i > OP_SDZ)
        AST_SKIP_ONLY: assert (!skip_o); // R11
      if (op_i > OP_SDZ)
        AST_UNDEF_QUIET: assert (result_o == 8'h00 && flags_we_o == 4'b0000); // R12
    end
  end
endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 32;

  logic       clk = 1'b0;
  logic [4:0] op;
  logic [7:0] a, b;
  logic       c, ac;
  logic [7:0] res;
  logic [3:0] flags, we;
  logic       skip;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags uut (
    .op_i(op), .acc_i(a), .opnd_i(b), .c_i(c), .ac_i(ac),
    .result_o(res), .flags_o(flags), .flags_we_o(we), .skip_o(skip)
  );

  // {op, a, b, c, ac, result, flags CACZOV, enables, skip}
  localparam logic [39:0] VEC [NVEC] = '{
    {5'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 4'b0101, 4'b1111, 1'b0}, // R2 R5
    {5'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b1110, 4'b1111, 1'b0}, // R2 R4
    {5'd1,  8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 4'b0000, 4'b1111, 1'b0}, // R2
    {5'd2,  8'h05, 8'h03, 1'b0, 1'b0, 8'h02, 4'b1100, 4'b1111, 1'b0}, // R3
    {5'd2,  8'h03, 8'h05, 1'b0, 1'b0, 8'hFE, 4'b0000, 4'b1111, 1'b0}, // R3
    {5'd2,  8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 4'b1001, 4'b1111, 1'b0}, // R3 R5
    {5'd3,  8'h05, 8'h05, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b1111, 1'b0}, // R3
    {5'd3,  8'h05, 8'h05, 1'b1, 1'b0, 8'h00, 4'b1110, 4'b1111, 1'b0}, // R3 R4
    {5'd4,  8'h3C, 8'h00, 1'b0, 1'b0, 8'h42, 4'b0000, 4'b1000, 1'b0}, // R6
    {5'd4,  8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000, 1'b0}, // R6
    {5'd4,  8'h15, 8'h00, 1'b0, 1'b1, 8'h1B, 4'b0000, 4'b1000, 1'b0}, // R6
    {5'd4,  8'h20, 8'h00, 1'b1, 1'b0, 8'h80, 4'b1000, 4'b1000, 1'b0}, // R6
    {5'd5,  8'hF0, 8'h0F, 1'b1, 1'b1, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R7
    {5'd6,  8'hA0, 8'h05, 1'b0, 1'b0, 8'hA5, 4'b0000, 4'b0010, 1'b0}, // R7
    {5'd7,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R7
    {5'd8,  8'h33, 8'hFF, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R7
    {5'd13, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R7
    {5'd14, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R7
    {5'd14, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b0010, 1'b0}, // R7
    {5'd9,  8'h00, 8'h81, 1'b0, 1'b0, 8'h03, 4'b0000, 4'b0000, 1'b0}, // R8
    {5'd10, 8'h00, 8'h81, 1'b0, 1'b0, 8'hC0, 4'b0000, 4'b0000, 1'b0}, // R8
    {5'd11, 8'h00, 8'h80, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000, 1'b0}, // R9
    {5'd12, 8'h00, 8'h01, 1'b1, 1'b0, 8'h80, 4'b1000, 4'b1000, 1'b0}, // R9
    {5'd11, 8'h00, 8'h40, 1'b1, 1'b0, 8'h81, 4'b0000, 4'b1000, 1'b0}, // R9
    {5'd15, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R10
    {5'd15, 8'h00, 8'h07, 1'b0, 1'b0, 8'h07, 4'b0000, 4'b0000, 1'b0}, // R10
    {5'd16, 8'h00, 8'h05, 1'b0, 1'b0, 8'h05, 4'b0000, 4'b0000, 1'b1}, // R10
    {5'd16, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0}, // R10
    {5'd17, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R10
    {5'd17, 8'h00, 8'h10, 1'b0, 1'b0, 8'h11, 4'b0000, 4'b0000, 1'b0}, // R10
    {5'd18, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R10
    {5'd18, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b0000, 1'b0}  // R10
  };

  task automatic apply(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic ci, input logic aci);
    @(posedge clk);
    #1;
    op = o; a = x; b = y; c = ci; ac = aci;
    #(CLK_PERIOD/2);
  endtask

  task automatic check(input string req, input logic [7:0] er, input logic [3:0] ef,
                       input logic [3:0] ew, input logic es);
    checks++;
    if (res !== er || we !== ew || skip !== es || ((flags ^ ef) & ew) !== 4'b0000) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h: res=%h flags=%b we=%b skip=%b, expected res=%h flags=%b we=%b skip=%b",
               req, op, a, b, res, flags, we, skip, er, ef, ew, es);
    end
  endtask

  initial begin
    op = 5'd0; a = 8'h00; b = 8'h00; c = 1'b0; ac = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][39:35], VEC[i][34:27], VEC[i][26:19], VEC[i][18], VEC[i][17]);
      check("R1 table", VEC[i][16:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
    end
    // R11: skip stays low for non-skip operations with a zero operand
    for (int o = 0; o < 15; o++) begin
      apply(5'(o), 8'h00, 8'h00, 1'b1, 1'b1);
      checks++;
      if (skip !== 1'b0) begin
        fails++;
        $display("FAIL R11 op=%0d skip=%b expected 0", o, skip);
      end
    end
    // R12: undefined opcodes are inert
    for (int o = 19; o < 32; o++) begin
      apply(5'(o), 8'hFF, 8'hFF, 1'b1, 1'b1);
      check("R12", 8'h00, 4'b0000, 4'b0000, 1'b0);
    end
    // R2 R3 R4 R5: sweep against arithmetic model
    for (int x = 0; x < 256; x += 5) begin
      for (int y = 0; y < 256; y += 7) begin
        logic [7:0] r;
        logic fc, fa, fv;
        apply(5'd0, 8'(x), 8'(y), 1'b0, 1'b0);
        r = 8'(x + y); fc = (x + y) > 255; fa = ((x % 16) + (y % 16)) > 15;
        fv = (x / 128 == y / 128) && (r[7] != 1'(x / 128));
        check("R2 sweep", r, {fc, fa, r == 8'h00, fv}, 4'b1111, 1'b0);
        apply(5'd2, 8'(x), 8'(y), 1'b0, 1'b0);
        r = 8'(x - y); fc = x >= y; fa = (x % 16) >= (y % 16);
        fv = (x / 128 != y / 128) && (r[7] != 1'(x / 128));
        check("R3 sweep", r, {fc, fa, r == 8'h00, fv}, 4'b1111, 1'b0);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule